// File: doc/BRIEF.md
# Interval Receive Signal Meters

This block gathers four statistics from a receive datapath over a measurement interval whose end is marked by a one-cycle pulse from an external timer. The statistics are a signed sum of receive samples (DC level), an unsigned sum of the magnitude of the slicer error (noise level), a saturating count of converter overflow events, and a count of symbols decided at the inner levels. A fifth sum, of a signal-quality sample, is compared with a programmable threshold at each interval end to drive an alarm level.

Every statistic has a running accumulator. When the interval ends, the closing value is copied into a holding register and the accumulator starts again from zero on the next cycle, so each sample falls into exactly one interval. A host reads the holding registers one byte at a time. For the 16-bit meters, reading the low byte captures the matching high byte in a shadow register. An immediately following high-byte read of the same meter returns that captured byte, so the two bytes always come from the same snapshot.

Top module: `rx_meter_bank`

## Requirements
- R1: After reset every readable address returns 0x00 and `snr_alarm` is 0.
- R2: The DC meter adds each sign-extended `dc_sample` taken with `smp_valid` into a 32-bit two's-complement sum. At the interval end, bits 31:16 of the sum are held and can be read as low byte at address 0 and high byte at address 1.
- R3: The overflow meter counts the cycles with `adc_ovf` high in an interval and stops at 255. The held count is read at address 6. Address 7 always reads 0x00.
- R4: The symbol meter counts the valid samples whose `sym_level` is 2'b01 (-1) or 2'b10 (+1). Samples with 2'b00 (-3) or 2'b11 (+3) leave it unchanged. The count stops at 0xFFFF and is read at address 4 (low byte) and address 5 (high byte).
- R5: The noise meter adds the magnitude of each valid `slicer_err`, a two's-complement value, into a 32-bit unsigned sum. Bits 31:16 of the sum are held and can be read at address 2 (low byte) and address 3 (high byte).
- R6: A sample given in the same cycle as `interval_end` counts toward the interval that is ending. The following interval starts from zero. Holding registers change only on a cycle with `interval_end`.
- R7: `rd_data` is valid in the cycle after `rd_en`. If a read falls in the same cycle as `interval_end`, it returns the holding value from before that snapshot.
- R8: A low-byte read (address 0, 2 or 4) captures the high byte of that meter. A high-byte read of the same meter that immediately follows it returns the captured byte. If any other read comes between the two, or no low-byte read came first, the high-byte read returns the current holding value.
- R9: At each interval end, `snr_alarm` is set to 1 if bits 31:16 of the interval's 32-bit `snr_sample` sum are strictly greater than `snr_thresh`, and to 0 otherwise. Between interval ends `snr_alarm` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| interval_end | input | 1 | Last cycle of the measurement interval |
| smp_valid | input | 1 | Qualifies the DC, error, symbol and quality inputs |
| dc_sample | input | 16 | Signed receive sample |
| slicer_err | input | 16 | Signed slicer error |
| sym_level | input | 2 | Decided symbol: 00=-3, 01=-1, 10=+1, 11=+3 |
| snr_sample | input | 16 | Unsigned quality sample |
| adc_ovf | input | 1 | Converter overflow event |
| snr_thresh | input | 16 | Alarm threshold |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | 3 | Host read address |
| rd_data | output | 8 | Host read data, one cycle after `rd_en` |
| snr_alarm | output | 1 | Quality alarm level |

## Verification
The host read and the interval snapshot can fall in the same cycle, and this is the case that matters most. The bench drives a low-byte read of the DC meter on the last sample cycle of an interval. It expects the old low byte in `rd_data` and the old high byte on the next high-byte read, and only after that does it expect the new snapshot. A second test lets a snapshot land between the low and high reads and expects the captured byte. A read of another address between the two reads must make the high read return the current holding byte.

// File: rtl/rx_meter_bank.sv
module rx_meter_bank #(
  parameter int SMP_W = 16,
  parameter int ACC_W = 32,
  parameter int OVF_W = 8,
  parameter int SYM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             interval_end,
  input  logic             smp_valid,
  input  logic [SMP_W-1:0] dc_sample,
  input  logic [SMP_W-1:0] slicer_err,
  input  logic [1:0]       sym_level,
  input  logic [SMP_W-1:0] snr_sample,
  input  logic             adc_ovf,
  input  logic [15:0]      snr_thresh,
  input  logic             rd_en,
  input  logic [2:0]       rd_addr,
  output logic [7:0]       rd_data,
  output logic             snr_alarm
);
  localparam int HW = 16;

  logic [ACC_W-1:0] dc_acc, nz_acc, snr_acc;
  logic [OVF_W-1:0] ovf_acc, ovf_hold;
  logic [SYM_W-1:0] sym_acc;
  logic [HW-1:0]    dc_hold, nz_hold, sym_hold;
  logic [7:0]       shadow;
  logic [1:0]       pair_sel;
  logic             pair_ok;

  wire [ACC_W-1:0] dc_ext  = {{(ACC_W-SMP_W){dc_sample[SMP_W-1]}}, dc_sample};
  wire [SMP_W-1:0] err_mag = slicer_err[SMP_W-1] ? (~slicer_err + 1'b1) : slicer_err;
  wire             is_one  = sym_level[1] ^ sym_level[0];

  wire [ACC_W-1:0] dc_next  = dc_acc  + (smp_valid ? dc_ext : '0);
  wire [ACC_W-1:0] nz_next  = nz_acc  + (smp_valid ? ACC_W'(err_mag) : '0);
  wire [ACC_W-1:0] snr_next = snr_acc + (smp_valid ? ACC_W'(snr_sample) : '0);
  wire [OVF_W-1:0] ovf_next = (adc_ovf && ovf_acc != '1) ? ovf_acc + 1'b1 : ovf_acc;
  wire [SYM_W-1:0] sym_next = (smp_valid && is_one && sym_acc != '1) ? sym_acc + 1'b1 : sym_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dc_acc <= '0; nz_acc <= '0; snr_acc <= '0; ovf_acc <= '0; sym_acc <= '0;
      dc_hold <= '0; nz_hold <= '0; sym_hold <= '0; ovf_hold <= '0;
      snr_alarm <= 1'b0;
    end else if (interval_end) begin
      dc_acc <= '0; nz_acc <= '0; snr_acc <= '0; ovf_acc <= '0; sym_acc <= '0;
      dc_hold   <= dc_next[ACC_W-1 -: HW];
      nz_hold   <= nz_next[ACC_W-1 -: HW];
      sym_hold  <= sym_next[HW-1:0];
      ovf_hold  <= ovf_next;
      snr_alarm <= snr_next[ACC_W-1 -: HW] > snr_thresh;
    end else begin
      dc_acc <= dc_next; nz_acc <= nz_next; snr_acc <= snr_next;
      ovf_acc <= ovf_next; sym_acc <= sym_next;
    end
  end

  logic [HW-1:0] word;
  always_comb begin
    case (rd_addr[2:1])
      2'd0:    word = dc_hold;
      2'd1:    word = nz_hold;
      2'd2:    word = sym_hold;
      default: word = {{(HW-OVF_W){1'b0}}, ovf_hold};
    endcase
  end

  wire is_meter16 = rd_addr[2:1] != 2'd3;
  wire lo_read    = is_meter16 && !rd_addr[0];
  wire pair_hit   = pair_ok && pair_sel == rd_addr[2:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data <= '0; shadow <= '0; pair_sel <= '0; pair_ok <= 1'b0;
    end else if (rd_en) begin
      pair_ok <= lo_read;
      if (lo_read) begin
        shadow   <= word[15:8];
        pair_sel <= rd_addr[2:1];
      end
      if (!is_meter16)   rd_data <= rd_addr[0] ? 8'h00 : word[7:0];
      else if (lo_read)  rd_data <= word[7:0];
      else               rd_data <= pair_hit ? shadow : word[15:8];
    end
  end
endmodule

// File: rtl/rx_meter_bank_chk.sv
module rx_meter_bank_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        interval_end,
  input logic        smp_valid,
  input logic [1:0]  sym_level,
  input logic        rd_en,
  input logic [2:0]  rd_addr,
  input logic [7:0]  rd_data,
  input logic        snr_alarm,
  input logic [31:0] dc_acc,
  input logic [31:0] nz_acc,
  input logic [7:0]  ovf_acc,
  input logic [15:0] sym_acc,
  input logic [15:0] dc_hold,
  input logic [15:0] nz_hold,
  input logic [15:0] sym_hold,
  input logic [7:0]  ovf_hold
);
  // R3
  a_r3_ovf_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_acc == 8'hFF && !interval_end) |=> ovf_acc == 8'hFF);
  // R4
  a_r4_outer_levels_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !(sym_level[1] ^ sym_level[0]) && !interval_end) |=> $stable(sym_acc));
  // R6
  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    interval_end |=> (dc_acc == 0 && nz_acc == 0 && ovf_acc == 0 && sym_acc == 0));
  a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !interval_end |=> ($stable(dc_hold) && $stable(nz_hold) && $stable(sym_hold) && $stable(ovf_hold)));
  // R8
  a_r8_coherent_pair: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en && rd_addr == 3'd0) && rd_en && rd_addr == 3'd1) |=> rd_data == $past(dc_hold[15:8], 2));
  // R9
  a_r9_alarm_held: assert property (@(posedge clk) disable iff (!rst_n)
    !interval_end |=> $stable(snr_alarm));
endmodule

bind rx_meter_bank rx_meter_bank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .interval_end(interval_end), .smp_valid(smp_valid),
  .sym_level(sym_level), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .snr_alarm(snr_alarm), .dc_acc(dc_acc), .nz_acc(nz_acc), .ovf_acc(ovf_acc),
  .sym_acc(sym_acc), .dc_hold(dc_hold), .nz_hold(nz_hold), .sym_hold(sym_hold),
  .ovf_hold(ovf_hold)
);

// File: tb/tb_rx_meter_bank.sv
`timescale 1ns/1ps
module tb_rx_meter_bank;
  logic        clk = 0, rst_n = 0;
  logic        interval_end = 0, smp_valid = 0, adc_ovf = 0, rd_en = 0;
  logic [15:0] dc_sample = 0, slicer_err = 0, snr_sample = 0, snr_thresh = 16'd2;
  logic [1:0]  sym_level = 0;
  logic [2:0]  rd_addr = 0;
  logic [7:0]  rd_data;
  logic        snr_alarm;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  rx_meter_bank dut (
    .clk(clk), .rst_n(rst_n), .interval_end(interval_end), .smp_valid(smp_valid),
    .dc_sample(dc_sample), .slicer_err(slicer_err), .sym_level(sym_level),
    .snr_sample(snr_sample), .adc_ovf(adc_ovf), .snr_thresh(snr_thresh),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .snr_alarm(snr_alarm)
  );

  localparam int          NV = 4;
  localparam int          V_LEN [NV] = '{4, 8, 300, 2};
  localparam logic [15:0] V_DC  [NV] = '{16'h4000, 16'hC000, 16'h0100, 16'hFFFF};
  localparam logic [15:0] V_ERR [NV] = '{16'hC000, 16'h7FFF, 16'h8000, 16'h0000};
  localparam logic        V_OVF [NV] = '{1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [1:0]  V_SYM [NV] = '{2'b01, 2'b11, 2'b10, 2'b00};
  localparam logic [15:0] V_SNR [NV] = '{16'hFFFF, 16'h0000, 16'h0100, 16'hFFFF};
  localparam logic [15:0] E_DC  [NV] = '{16'h0001, 16'hFFFE, 16'h0001, 16'hFFFF};
  localparam logic [15:0] E_NZ  [NV] = '{16'h0001, 16'h0003, 16'h0096, 16'h0000};
  localparam logic [15:0] E_SYM [NV] = '{16'h0004, 16'h0000, 16'h012C, 16'h0000};
  localparam logic [7:0]  E_OVF [NV] = '{8'h04, 8'h00, 8'hFF, 8'h02};
  localparam logic        E_ALM [NV] = '{1'b1, 1'b0, 1'b0, 1'b0};

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0; d = rd_data;
  endtask

  task automatic rd16(input logic [2:0] a, output logic [15:0] w);
    logic [7:0] lo, hi;
    rd(a, lo); rd(a + 3'd1, hi);
    w = {hi, lo};
  endtask

  task automatic run_iv(input int len, input logic [15:0] dc, input logic [15:0] err,
                        input logic ovf, input logic [1:0] sym, input logic [15:0] snr,
                        input logic rd_last, input logic [2:0] a);
    if (len == 0) begin
      @(negedge clk); interval_end = 1;
    end
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      smp_valid = 1; dc_sample = dc; slicer_err = err; adc_ovf = ovf;
      sym_level = sym; snr_sample = snr;
      interval_end = (i == len - 1);
      rd_en = rd_last && (i == len - 1); rd_addr = a;
    end
    @(negedge clk);
    smp_valid = 0; adc_ovf = 0; interval_end = 0; rd_en = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] w;
    logic [7:0]  b;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), b);
      check("R1 reset read", {8'h00, b}, 16'h0000);
    end
    check("R1 reset alarm", {15'd0, snr_alarm}, 16'h0000);

    // vector table: R2 R3 R4 R5 R9
    for (int v = 0; v < NV; v++) begin
      run_iv(V_LEN[v], V_DC[v], V_ERR[v], V_OVF[v], V_SYM[v], V_SNR[v], 1'b0, 3'd0);
      rd16(3'd0, w); check("R2 dc meter", w, E_DC[v]);
      rd16(3'd2, w); check("R5 noise meter", w, E_NZ[v]);
      rd16(3'd4, w); check("R4 symbol meter", w, E_SYM[v]);
      rd(3'd6, b);   check("R3 overflow meter", {8'h00, b}, {8'h00, E_OVF[v]});
      check("R9 alarm", {15'd0, snr_alarm}, {15'd0, E_ALM[v]});
    end

    // R6 empty interval clears everything
    run_iv(0, 0, 0, 0, 0, 0, 1'b0, 3'd0);
    rd16(3'd0, w); check("R6 empty dc", w, 16'h0000);
    rd16(3'd4, w); check("R6 empty sym", w, 16'h0000);
    rd(3'd6, b);   check("R6 empty ovf", {8'h00, b}, 16'h0000);

    // R8 snapshot between low and high reads
    run_iv(4, 16'h4000, 0, 0, 2'b00, 0, 1'b0, 3'd0);
    rd(3'd0, b); check("R8 low byte", {8'h00, b}, 16'h0001);
    run_iv(8, 16'hC000, 0, 0, 2'b00, 0, 1'b0, 3'd0);
    rd(3'd1, b); check("R8 captured high", {8'h00, b}, 16'h0000);
    rd(3'd0, b); check("R8 new low", {8'h00, b}, 16'h00FE);
    rd(3'd6, b);
    rd(3'd1, b); check("R8 broken pair", {8'h00, b}, 16'h00FF);
    rd(3'd7, b); check("R3 unused address", {8'h00, b}, 16'h0000);

    // R7 low-byte read in the snapshot cycle
    run_iv(4, 16'h4000, 0, 0, 2'b00, 0, 1'b1, 3'd0);
    check("R7 read at snapshot", {8'h00, rd_data}, 16'h00FE);
    rd(3'd1, b); check("R7 high after same-cycle low", {8'h00, b}, 16'h00FF);
    rd16(3'd0, w); check("R6 new snapshot", w, 16'h0001);

    // R9 threshold boundary and hold between intervals
    snr_thresh = 16'd3;
    run_iv(4, 0, 0, 0, 2'b00, 16'hFFFF, 1'b0, 3'd0);
    check("R9 equal not above", {15'd0, snr_alarm}, 16'h0000);
    snr_thresh = 16'd2;
    run_iv(4, 0, 0, 0, 2'b00, 16'hFFFF, 1'b0, 3'd0);
    check("R9 above", {15'd0, snr_alarm}, 16'h0001);
    snr_thresh = 16'hFFFF;
    repeat (5) @(negedge clk);
    check("R9 held until interval end", {15'd0, snr_alarm}, 16'h0001);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule